// File: doc/BRIEF.md
# Strap-configured command register with fan-out

This block sits between a memory controller and a group of memory devices. On each rising clock edge it captures a command and address bus and presents the captured value on its outputs. Two static strap inputs choose how the captured bits reach the outputs. The first choice is a wide one-to-one register. The other two are narrower modes in which each captured bit drives two identical output copies. These two fan-out layouts differ only in where the clock-enable and termination-control bits sit.

Two chip-select inputs save power. When both are high at a clock edge, the ordinary bits keep their previous value. Three control bits are exempt from this gating: clock-enable, termination-control and chip-select. They load on every edge. A reset clears the register and holds every output low. The straps are meant to be wired to fixed levels, and they are changed only while reset is applied.

Top module: `rcb_cmd_register`

## Requirements
- R1: With `strap_c1` = 0 the block is a 25-bit one-to-one register. Input bit i is captured and appears on `q_main[i]`, and all 25 bits are used.
- R2: With `strap_c1` = 1 the block is a 14-bit register. `q_copy[13:0]` always equals `q_main[13:0]`, so each captured bit drives two copies.
- R3: The exempt bits sit at fixed positions. In wide mode and in fan-out layout A (`strap_c0` = 0) they are bits 0, 3 and 6. In fan-out layout B (`strap_c0` = 1) they are bits 13, 10 and 6, and bit 6 (chip-select) stays in place.
- R4: When `cs_dimm` and `cs_rank` are both 1 at a clock edge, every non-exempt active output bit holds its previous value.
- R5: The exempt bits of the current mode load the input on every clock edge, whatever the state of the chip-select inputs.
- R6: If either chip-select input is 0, every active bit loads. Tying `cs_rank` to 0 therefore disables gating.
- R7: In wide mode `q_copy` is driven to all zeros.
- R8: In the fan-out modes, inputs 14 to 24 are ignored and `q_main[24:14]` stays 0.
- R9: `rst` is synchronous and active high, and it takes priority over chip-select gating. At an edge where `rst` is 1, all outputs become 0. After release, the outputs stay 0 until a nonzero value is captured.
- R10: A value present on `d_in` at a loading edge is visible on the outputs immediately after that edge. There is exactly one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst | input | 1 | Synchronous active-high clear |
| strap_c0 | input | 1 | Fan-out layout select (0 = A, 1 = B) |
| strap_c1 | input | 1 | Width select (0 = 25-bit one-to-one, 1 = 14-bit one-to-two) |
| cs_dimm | input | 1 | Module chip-select, gating when high together with cs_rank |
| cs_rank | input | 1 | Second chip-select, tie low to disable gating |
| d_in | input | 25 | Command and address bus; bit 0 is the first input |
| q_main | output | 25 | Captured bus, first copy in fan-out modes |
| q_copy | output | 14 | Second copy in fan-out modes, zero in wide mode |

## Verification
The bench builds the block with its default parameters: a 25-bit wide register, a 14-bit fan-out register, and exempt positions 0, 3 and 6 or 13, 10 and 6. With these values all three strap modes can be reached, including the relocation of the exempt bits in layout B and the upper outputs that go quiet in the fan-out modes. Random data is applied under each chip-select pattern: gated, ungated, and `cs_rank` tied low. A behavioural model predicts every output bit on each clock, so a held ordinary bit or a loaded exempt bit is checked in every mode.

// File: rtl/rcb_pkg.sv
package rcb_pkg;
  typedef enum logic [1:0] {
    MODE_WIDE  = 2'd0,
    MODE_FAN_A = 2'd1,
    MODE_FAN_B = 2'd2
  } rcb_mode_e;
endpackage

// File: rtl/rcb_strap_decode.sv
module rcb_strap_decode
  import rcb_pkg::*;
#(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14,
  parameter int CKE_A    = 0,
  parameter int ODT_A    = 3,
  parameter int CS_POS   = 6,
  parameter int CKE_B    = 13,
  parameter int ODT_B    = 10
) (
  input  logic              strap_c0,
  input  logic              strap_c1,
  output rcb_mode_e         mode,
  output logic [WIDE_W-1:0] active_mask,
  output logic [WIDE_W-1:0] exempt_mask
);
  always_comb begin
    if (!strap_c1)     mode = MODE_WIDE;
    else if (strap_c0) mode = MODE_FAN_B;
    else               mode = MODE_FAN_A;
  end

  // Per-bit masks: which positions are live, and which ignore chip-select.
  for (genvar i = 0; i < WIDE_W; i++) begin : g_mask
    localparam bit IN_NARROW = (i < NARROW_W);
    localparam bit EX_A      = (i == CKE_A) || (i == ODT_A) || (i == CS_POS);
    localparam bit EX_B      = (i == CKE_B) || (i == ODT_B) || (i == CS_POS);
    assign active_mask[i] = (mode == MODE_WIDE) || IN_NARROW;
    assign exempt_mask[i] = (mode == MODE_FAN_B) ? EX_B : EX_A;
  end
endmodule

// File: rtl/rcb_capture.sv
module rcb_capture #(
  parameter int W = 25
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  input  logic [W-1:0] active_mask,
  input  logic [W-1:0] load_en,
  output logic [W-1:0] state
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)             state[i] <= 1'b0;
      else if (load_en[i]) state[i] <= d[i] & active_mask[i];
    end
  end

  // An inactive position never holds a one once out of reset.
  for (genvar i = 0; i < W; i++) begin : g_chk
    AST_INACTIVE_ZERO: assert property (@(posedge clk) disable iff (rst)
      !$past(active_mask[i]) && !$past(rst) |-> !state[i]); // R8
  end
endmodule

// File: rtl/rcb_fanout.sv
module rcb_fanout
  import rcb_pkg::*;
#(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14
) (
  input  rcb_mode_e           mode,
  input  logic [WIDE_W-1:0]   state,
  input  logic [WIDE_W-1:0]   active_mask,
  output logic [WIDE_W-1:0]   q_main,
  output logic [NARROW_W-1:0] q_copy
);
  localparam int CW = NARROW_W;
  logic copy_on;
  assign copy_on = (mode != MODE_WIDE);

  for (genvar i = 0; i < WIDE_W; i++) begin : g_main
    assign q_main[i] = state[i] & active_mask[i];
  end
  for (genvar i = 0; i < CW; i++) begin : g_copy
    assign q_copy[i] = state[i] & copy_on;
  end
endmodule

// File: rtl/rcb_cmd_register.sv
module rcb_cmd_register
  import rcb_pkg::*;
#(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14,
  parameter int CKE_A    = 0,
  parameter int ODT_A    = 3,
  parameter int CS_POS   = 6,
  parameter int CKE_B    = 13,
  parameter int ODT_B    = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                strap_c0,
  input  logic                strap_c1,
  input  logic                cs_dimm,
  input  logic                cs_rank,
  input  logic [WIDE_W-1:0]   d_in,
  output logic [WIDE_W-1:0]   q_main,
  output logic [NARROW_W-1:0] q_copy
);
  localparam int UPPER_W = WIDE_W - NARROW_W;

  rcb_mode_e         mode;
  logic [WIDE_W-1:0] active_mask;
  logic [WIDE_W-1:0] exempt_mask;
  logic [WIDE_W-1:0] load_en;
  logic [WIDE_W-1:0] state;
  logic              gated;

  rcb_strap_decode #(
    .WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .CKE_A(CKE_A), .ODT_A(ODT_A),
    .CS_POS(CS_POS), .CKE_B(CKE_B), .ODT_B(ODT_B)
  ) i_decode (
    .strap_c0(strap_c0), .strap_c1(strap_c1), .mode(mode),
    .active_mask(active_mask), .exempt_mask(exempt_mask)
  );

  assign gated   = cs_dimm & cs_rank;
  // Inactive bits always load so that they settle to zero.
  assign load_en = exempt_mask | ~active_mask | {WIDE_W{~gated}};

  rcb_capture #(.W(WIDE_W)) i_capture (
    .clk(clk), .rst(rst), .d(d_in), .active_mask(active_mask),
    .load_en(load_en), .state(state)
  );

  rcb_fanout #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) i_fanout (
    .mode(mode), .state(state), .active_mask(active_mask),
    .q_main(q_main), .q_copy(q_copy)
  );

  AST_STRAPS_STATIC: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable({strap_c0, strap_c1})); // R1
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (q_main == '0) && (q_copy == '0)); // R9
  AST_GATED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cs_dimm && cs_rank) |=> ((q_main & ~exempt_mask) == ($past(q_main) & ~exempt_mask))); // R4
  AST_CS_BIT_LOADS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> q_main[CS_POS] == $past(d_in[CS_POS])); // R5
  AST_UNGATED_LOADS: assert property (@(posedge clk) disable iff (rst)
    (!cs_rank && !strap_c1) |=> q_main == $past(d_in)); // R6
  AST_COPY_MATCH: assert property (@(posedge clk) disable iff (rst)
    strap_c1 |-> q_copy == q_main[NARROW_W-1:0]); // R2
  AST_WIDE_COPY_LOW: assert property (@(posedge clk) disable iff (rst)
    !strap_c1 |-> q_copy == '0); // R7
  AST_UPPER_LOW: assert property (@(posedge clk) disable iff (rst)
    strap_c1 |-> q_main[WIDE_W-1:NARROW_W] == {UPPER_W{1'b0}}); // R8
endmodule

// File: tb/test_rcb_cmd_register.sv
module test_rcb_cmd_register;
  localparam int W = 25;
  localparam int N = 14;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst = 1'b1;
  logic         c0 = 1'b0, c1 = 1'b0, csd = 1'b1, csr = 1'b1;
  logic [W-1:0] d = '0;
  logic [W-1:0] q_main;
  logic [N-1:0] q_copy;

  int    n_tests = 0, n_fail = 0, cyc = 0;
  string req = "R9";
  logic [W-1:0] model = '0;

  rcb_cmd_register i_rcb_cmd_register (
    .clk(clk), .rst(rst), .strap_c0(c0), .strap_c1(c1), .cs_dimm(csd),
    .cs_rank(csr), .d_in(d), .q_main(q_main), .q_copy(q_copy)
  );

  // R3 exempt positions
  function automatic bit is_exempt(int i);
    if (c1 && c0) return (i == 6) || (i == 10) || (i == 13);
    return (i == 0) || (i == 3) || (i == 6);
  endfunction

  // Behavioural reference, one stage
  always @(posedge clk) begin
    if (rst) model <= '0;
    else
      for (int i = 0; i < W; i++) begin
        if (c1 && i >= N) model[i] <= 1'b0;
        else if (!(csd && csr) || is_exempt(i)) model[i] <= d[i];
      end
  end

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    check(req, q_main, model);
    check(req, W'(q_copy), c1 ? W'(model[N-1:0]) : '0);
  endtask

  task automatic burst(string tag, bit vd, bit vr, int n);
    req = tag; csd = vd; csr = vr;
    for (int k = 0; k < n; k++) begin
      d = W'($urandom);
      step();
    end
  endtask

  task automatic run_mode(bit v1, bit v0, string mode_tag);
    rst = 1'b1; c1 = v1; c0 = v0; csd = 1'b1; csr = 1'b1;
    d = W'($urandom);
    req = "R9"; step(); step();
    rst = 1'b0; d = '0; step();
    check("R9", q_main, '0);
    burst("R10", 1'b0, 1'b1, 20);
    burst(mode_tag, 1'b1, 1'b1, 20);   // gated: ordinary hold, exempt load
    burst("R4", 1'b1, 1'b1, 10);
    burst("R5", 1'b0, 1'b0, 5);
    burst("R5", 1'b1, 1'b1, 10);
    burst("R6", 1'b1, 1'b0, 15);
    if (!v1) check("R7", W'(q_copy), '0);
    else     check("R8", W'(q_main[W-1:N]), '0);
    // reset mid-run while gated: reset wins
    rst = 1'b1; csd = 1'b1; csr = 1'b1; d = '1; req = "R9"; step();
    check("R9", q_main, '0);
    rst = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog act=running exp=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    req = "R9"; step();
    check("R9", q_main, '0);
    run_mode(1'b0, 1'b0, "R1");
    run_mode(1'b1, 1'b0, "R2");
    run_mode(1'b1, 1'b1, "R3");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule